// File: doc/BRIEF.md
# Retriggerable Power-On Reset Generator

This block produces the processor reset from two causes. One is a digital flag that is set while the supply is below its threshold. The other is an active-low manual reset request. Reset is asserted for as long as either cause is present. Once both causes have gone away, reset stays asserted for a further hold time of `HOLD_TICKS` clock edges. A new cause that arrives during the hold throws away the remaining time, and a full hold starts again when that cause ends. Because of this, a bouncing manual switch gives a single clean reset pulse.

The manual input can come from a switch or from another logic block, so it passes through a synchronizer of `SYNC_STAGES` flops before use. The supply flag is taken to be synchronous to the clock already. The threshold comparator and the analog reference are outside this block. Reset is presented in three forms:
- an active-high output;
- its active-low complement;
- a reset-active status, which the watchdog uses to hold its timer cleared.

A build-time option removes the manual path entirely. The manual input is then treated as permanently released.

Top module: `por_hold_gen`

## Requirements
- R1: When `supply_low_i` is sampled high at a clock edge, `rst_o` is high after that edge, and it stays high for every cycle in which the flag is still set.
- R2: After the last clock edge at which a cause was present, `rst_o` stays high for exactly `HOLD_TICKS` further edges with no cause, and it goes low right after the last of those edges.
- R3: A cause that appears while the hold is running restarts the hold in full, so the release comes `HOLD_TICKS` cause-free edges after the end of that new cause.
- R4: `man_rst_n_i` is active low. A low level reaches the reset logic after `SYNC_STAGES` edges, so with 2 stages `rst_o` rises right after the third edge that follows the input going low. The release is delayed by the same `SYNC_STAGES` edges.
- R5: A manual low lasting a single clock cycle still produces a full hold. A bouncing manual input gives one continuous reset pulse that ends `HOLD_TICKS` cause-free edges after the last bounce.
- R6: `rst_n_o` is at all times the exact complement of `rst_o`, and `rst_active_o` always equals `rst_o`.
- R7: Before the first clock edge, `rst_o` is high and `rst_n_o` is low. The synchronizer starts out holding a low level. So with `MAN_ENABLE=1` and the manual input held high, the first release comes right after edge `SYNC_STAGES+HOLD_TICKS`. With `MAN_ENABLE=0`, the first release comes right after edge `HOLD_TICKS`.
- R8: With `MAN_ENABLE=0`, `man_rst_n_i` has no effect: a low level on it never raises `rst_o`. This models an unused manual input, which counts as released (high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| supply_low_i | input | 1 | Supply-below-threshold flag, active high, synchronous to `clk_i` |
| man_rst_n_i | input | 1 | Manual reset request, active low, asynchronous |
| rst_o | output | 1 | Reset to the processor, active high |
| rst_n_o | output | 1 | Reset to the processor, active low |
| rst_active_o | output | 1 | Reset-active status to the watchdog |

## Verification
The supply flag is exercised as an isolated long pulse and as two pulses where the second lands inside the first one's hold. The first case measures the exact hold length. The second shows whether the counter is reloaded or only left to continue. The manual input is driven with a long low, a single-cycle glitch and a burst of bounces. These separate the synchronizer latency on the way in and on the way out, and they show that a one-cycle request is stretched to a full hold. A second instance, built without the manual path, sees the same manual activity, which shows that the option really disconnects the input. Both instances are also checked in the power-up window before the first edge and up to their first release.

// File: rtl/por_hold_pkg.sv
package por_hold_pkg;
   // Width needed to hold the value 0..max_val.
   function automatic int cnt_width(input longint max_val);
      int w;
      w = 1;
      while ((longint'(1) << w) <= max_val) w++;
      return w;
   endfunction
endpackage

// File: rtl/por_sync.sv
module por_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic d_i,
   output logic q_o
);
   // The flops start at 0: an active-low request is seen as pressed at power-up.
   logic [STAGES-1:0] stage_q = '0;

   initial begin
      if (STAGES < 2) $error("por_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk_i) begin
      stage_q[0] <= d_i;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_chain
      always_ff @(posedge clk_i) begin
         stage_q[g] <= stage_q[g-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/por_hold_cnt.sv
module por_hold_cnt
   import por_hold_pkg::*;
#(
   parameter longint HOLD_TICKS = 25_000_000
) (
   input  logic clk_i,
   input  logic cause_i,
   output logic active_o
);
   localparam int CNT_W = cnt_width(HOLD_TICKS);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(HOLD_TICKS);

   // The counter starts full and the output starts asserted.
   logic [CNT_W-1:0] cnt_q    = FULL;
   logic             active_q = 1'b1;
   logic [CNT_W-1:0] cnt_nxt;
   logic             run_q    = 1'b0;

   initial begin
      if (HOLD_TICKS < 1) $error("por_hold_cnt: HOLD_TICKS must be at least 1");
   end

   always_comb begin
      if (cause_i)
         cnt_nxt = FULL;
      else if (cnt_q != '0)
         cnt_nxt = cnt_q - 1'b1;
      else
         cnt_nxt = cnt_q;
   end

   always_ff @(posedge clk_i) begin
      cnt_q    <= cnt_nxt;
      active_q <= (cnt_nxt != '0);
      run_q    <= 1'b1;
   end

   assign active_o = active_q;

   AST_RELOAD_ON_CAUSE: assert property (@(posedge clk_i) disable iff (!run_q)
      cause_i |=> (cnt_q == FULL) && active_q);                       // R3
   AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!run_q)
      (!cause_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);    // R2
   AST_NO_EARLY_RELEASE: assert property (@(posedge clk_i) disable iff (!run_q)
      $fell(active_q) |-> $past(cnt_q) == CNT_W'(1));                 // R2
endmodule

// File: rtl/por_hold_gen.sv
module por_hold_gen #(
   parameter longint HOLD_TICKS  = 25_000_000,
   parameter int     SYNC_STAGES = 2,
   parameter bit     MAN_ENABLE  = 1'b1
) (
   input  logic clk_i,
   input  logic supply_low_i,
   input  logic man_rst_n_i,
   output logic rst_o,
   output logic rst_n_o,
   output logic rst_active_o
);
   logic man_n_sync;
   logic cause;
   logic hold_act;
   logic run_q = 1'b0;

   if (MAN_ENABLE) begin : g_man
      por_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk_i (clk_i),
         .d_i   (man_rst_n_i),
         .q_o   (man_n_sync)
      );
   end else begin : g_no_man
      logic unused_man;
      assign unused_man = man_rst_n_i;
      assign man_n_sync = 1'b1;
   end

   assign cause = supply_low_i | ~man_n_sync;

   por_hold_cnt #(.HOLD_TICKS(HOLD_TICKS)) i_cnt (
      .clk_i    (clk_i),
      .cause_i  (cause),
      .active_o (hold_act)
   );

   assign rst_o        = hold_act;
   assign rst_n_o      = ~hold_act;
   assign rst_active_o = hold_act;

   always_ff @(posedge clk_i) run_q <= 1'b1;

   AST_SUPPLY_HOLDS_RST: assert property (@(posedge clk_i) disable iff (!run_q)
      supply_low_i |=> rst_o);                                        // R1
   AST_RELEASE_NEEDS_QUIET: assert property (@(posedge clk_i) disable iff (!run_q)
      $fell(rst_o) |-> !$past(supply_low_i));                         // R2
   AST_OUTS_OPPOSITE: assert property (@(posedge clk_i) disable iff (!run_q)
      (rst_o != rst_n_o) && (rst_active_o == rst_o));                 // R6
endmodule

// File: tb/test_por_hold_gen.sv
module test_por_hold_gen;
   localparam int HOLD = 20;

   typedef struct {
      int    cyc;
      int    which;
      bit    exp;
      string req;
   } item_t;

   logic clk = 1'b0;
   logic supply_low = 1'b0;
   logic man_n = 1'b1;
   logic rst_a, rst_n_a, act_a;
   logic rst_b, rst_n_b, act_b;
   int   cyc = 0;
   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;
   item_t q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   por_hold_gen #(.HOLD_TICKS(HOLD), .SYNC_STAGES(2), .MAN_ENABLE(1'b1)) i_por_hold_gen (
      .clk_i(clk), .supply_low_i(supply_low), .man_rst_n_i(man_n),
      .rst_o(rst_a), .rst_n_o(rst_n_a), .rst_active_o(act_a));

   por_hold_gen #(.HOLD_TICKS(HOLD), .SYNC_STAGES(2), .MAN_ENABLE(1'b0)) i_por_hold_gen_noman (
      .clk_i(clk), .supply_low_i(supply_low), .man_rst_n_i(man_n),
      .rst_o(rst_b), .rst_n_o(rst_n_b), .rst_active_o(act_b));

   task automatic check(input string req, input bit act, input bit exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s cyc=%0d actual=%0b expected=%0b", req, cyc, act, exp);
      end
   endtask

   // Scoreboard push, kept sorted by cycle.
   task automatic push(input int c, input int which, input bit exp, input string req);
      item_t it;
      int pos;
      it.cyc = c; it.which = which; it.exp = exp; it.req = req;
      pos = q.size();
      for (int i = 0; i < q.size(); i++) begin
         if (q[i].cyc > c) begin pos = i; break; end
      end
      q.insert(pos, it);
   endtask

   // Monitor: sample away from the active edge.
   always @(negedge clk) begin
      check("R6", rst_n_a, ~rst_a);
      check("R6", act_a, rst_a);
      check("R6", rst_n_b, ~rst_b);
      check("R6", act_b, rst_b);
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         item_t it;
         it = q.pop_front();
         if (it.cyc < cyc) begin
            total++; bad++;
            $display("FAIL %s missed cyc=%0d actual=late expected=%0b", it.req, it.cyc, it.exp);
         end else begin
            check(it.req, (it.which == 0) ? rst_a : rst_b, it.exp);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic sup_pulse(input int len, input bit from_idle, input bit exp_rel);
      int c;
      c = cyc;
      supply_low = 1'b1;
      if (from_idle) begin push(c, 0, 1'b0, "R1"); push(c, 1, 1'b0, "R1"); end
      push(c + 1, 0, 1'b1, "R1");
      push(c + 1, 1, 1'b1, "R1");
      push(c + len, 0, 1'b1, "R1");
      step(len);
      supply_low = 1'b0;
      c = cyc;
      if (exp_rel) begin
         push(c + HOLD - 1, 0, 1'b1, "R2"); push(c + HOLD, 0, 1'b0, "R2");
         push(c + HOLD - 1, 1, 1'b1, "R3"); push(c + HOLD, 1, 1'b0, "R3");
      end
   endtask

   task automatic man_pulse(input int len, input bit from_idle, input bit exp_rel, input string req);
      int c;
      c = cyc;
      man_n = 1'b0;
      if (from_idle) push(c + 2, 0, 1'b0, "R4");
      push(c + 3, 0, 1'b1, req);
      push(c + 3, 1, 1'b0, "R8");
      step(len);
      man_n = 1'b1;
      c = cyc;
      if (exp_rel) begin
         push(c + 1 + HOLD, 0, 1'b1, req);
         push(c + 2 + HOLD, 0, 1'b0, req);
         push(c + 2 + HOLD, 1, 1'b0, "R8");
      end
   endtask

   initial begin
      #1;
      check("R7", rst_a, 1'b1);
      check("R7", rst_n_a, 1'b0);
      check("R7", rst_b, 1'b1);
      check("R7", rst_n_b, 1'b0);
      push(HOLD + 1, 0, 1'b1, "R7"); push(HOLD + 2, 0, 1'b0, "R7");
      push(HOLD - 1, 1, 1'b1, "R7"); push(HOLD, 1, 1'b0, "R7");
      step(30);
      // Isolated supply pulse: exact hold length.
      sup_pulse(6, 1'b1, 1'b1);
      step(HOLD + 8);
      // Second brownout inside the hold restarts it.
      sup_pulse(3, 1'b1, 1'b0);
      step(10);
      sup_pulse(2, 1'b0, 1'b1);
      step(HOLD + 8);
      // Long manual low.
      man_pulse(8, 1'b1, 1'b1, "R4");
      step(HOLD + 8);
      // Single-cycle glitch gets a full hold.
      man_pulse(1, 1'b1, 1'b1, "R5");
      step(HOLD + 8);
      // Bouncing switch: one continuous pulse.
      man_pulse(1, 1'b1, 1'b0, "R5");
      step(5);
      man_pulse(1, 1'b0, 1'b0, "R5");
      step(3);
      man_pulse(2, 1'b0, 1'b1, "R5");
      push(cyc + 10, 0, 1'b1, "R5");
      step(HOLD + 8);
      if (q.size() != 0) begin
         total++; bad++;
         $display("FAIL scoreboard actual=%0d expected=0 pending items", q.size());
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 5000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule